// File: doc/BRIEF.md
# NMI Edge Detector with Overrun Flag

This block watches a single non-maskable interrupt pad. It records qualifying transitions in a small status register that software can read and clear. The pad is brought into the clock domain through a synchroniser. Each transition is then compared against two enable bits held in a configuration register, one for rising transitions and one for falling transitions. A qualifying transition raises a pending flag. The overrun flag is loaded on every new event with the value the pending flag held just before that event, so it marks an event that arrives while the previous one is still unserviced.

Software reaches the two registers over a simple bus made of a byte address, write data, a write strobe and read data. Both flags clear only when a 1 is written to them. An interrupt output is driven from a register and stays asserted while either flag is set and edge detection is enabled in at least one direction.

Top module: `nmi_edge_monitor`

## Requirements
- R1: After synchronous reset the status register, the configuration register, the read data and the interrupt output are all zero.
- R2: Read data appears one clock after the address is presented. Offset 0x0 returns the status register, with the pending flag in data bit 31 and the overrun flag in data bit 30; all of its other bits read zero. Offset 0x8 returns the configuration register, with the rising enable in data bit 0 and the falling enable in data bit 1. Every other offset reads zero.
- R3: A pad change that is sampled at clock edge k sets the pending flag at edge k+2, after two synchroniser stages and one edge-compare stage.
- R4: With only the rising enable set, only 0-to-1 pad transitions are events. With only the falling enable set, only 1-to-0 transitions are events. With both set, transitions in either direction are events.
- R5: A write to offset 0x0 clears each flag whose data bit is 1. A flag whose data bit is 0 keeps its value.
- R6: On each event the overrun flag takes the value the pending flag held just before the event. It therefore becomes 1 if pending was still set, and becomes 0 if pending had been cleared.
- R7: The interrupt output is registered. It is 1 in the cycle after a cycle in which either flag is set and at least one enable bit is 1, and it is 0 in the cycle after a cycle in which both flags are clear.
- R8: When an event and a clearing write fall in the same cycle, the event wins. The pending flag ends up 1 and the overrun flag ends up as the copy of the old pending value.
- R9: With both enable bits clear, no pad transition sets either flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pad_i | input | 1 | Asynchronous NMI pad level |
| bus_addr | input | ADDR_W (14) | Byte address of the register access |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_rdata | output | DATA_W (32) | Registered read data for the previous cycle's address |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions check the per-cycle flag rules on every clock: an event sets the pending flag, an event copies pending into overrun, a clearing write loses to a concurrent event, 1-bits clear and 0-bits hold, no event is raised while both enables are off, the interrupt follows the flags one cycle late, and the reserved status bits stay zero. Only the bench scenarios show the end-to-end pad-to-flag latency through the synchroniser, the selection of edge direction for each enable setting, the overrun flag returning to zero when pending was cleared before a new event, and the register map and read latency as seen at the bus.

// File: rtl/nmi_pkg.sv
package nmi_pkg;
  // register offsets (byte addresses)
  localparam int unsigned STAT_OFS = 32'h0000;
  localparam int unsigned CFG_OFS  = 32'h0008;
  // status bit positions counted from the MSB
  localparam int unsigned PEND_MSB0 = 0;
  localparam int unsigned OVF_MSB0  = 1;
  // configuration bit positions counted from the LSB
  localparam int unsigned CFG_RISE_BIT = 0;
  localparam int unsigned CFG_FALL_BIT = 1;

  typedef struct packed {
    logic rise;
    logic fall;
  } edge_cfg_t;
endpackage

// File: rtl/nmi_pad_sync.sv
module nmi_pad_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sr[STAGES-1];
endmodule

// File: rtl/nmi_edge_detect.sv
module nmi_edge_detect
  import nmi_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      lvl,
  input  edge_cfg_t cfg,
  output logic      evt
);
  logic prev;
  logic rise_seen;
  logic fall_seen;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= lvl;
  end

  always_comb begin
    rise_seen = lvl & ~prev;
    fall_seen = ~lvl & prev;
    evt = (rise_seen & cfg.rise) | (fall_seen & cfg.fall);
  end
endmodule

// File: rtl/nmi_flag_regs.sv
module nmi_flag_regs (
  input  logic clk,
  input  logic rst,
  input  logic evt,
  input  logic clr_pend,
  input  logic clr_ovf,
  input  logic irq_en,
  output logic pend,
  output logic ovf,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      ovf  <= 1'b0;
      irq  <= 1'b0;
    end else begin
      if (evt) begin
        pend <= 1'b1;
        ovf  <= pend;
      end else begin
        pend <= pend & ~clr_pend;
        ovf  <= ovf & ~clr_ovf;
      end
      irq <= (pend | ovf) & irq_en;
    end
  end
endmodule

// File: rtl/nmi_edge_monitor.sv
module nmi_edge_monitor
  import nmi_pkg::*;
#(
  parameter int unsigned ADDR_W      = 14,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pad_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  localparam int unsigned PEND_POS = DATA_W - 1 - PEND_MSB0;
  localparam int unsigned OVF_POS  = DATA_W - 1 - OVF_MSB0;
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);
  localparam logic [ADDR_W-1:0] CFG_A  = ADDR_W'(CFG_OFS);

  logic      pad_s;
  logic      edge_evt;
  logic      pend;
  logic      ovf;
  logic      rise_en;
  logic      fall_en;
  edge_cfg_t cfg;
  logic      stat_wr;
  logic      cfg_wr;

  assign stat_wr  = bus_we && (bus_addr == STAT_A);
  assign cfg_wr   = bus_we && (bus_addr == CFG_A);
  assign cfg.rise = rise_en;
  assign cfg.fall = fall_en;

  nmi_pad_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_i),
    .q   (pad_s)
  );

  nmi_edge_detect u_edge (
    .clk (clk),
    .rst (rst),
    .lvl (pad_s),
    .cfg (cfg),
    .evt (edge_evt)
  );

  nmi_flag_regs u_flags (
    .clk      (clk),
    .rst      (rst),
    .evt      (edge_evt),
    .clr_pend (stat_wr & bus_wdata[PEND_POS]),
    .clr_ovf  (stat_wr & bus_wdata[OVF_POS]),
    .irq_en   (rise_en | fall_en),
    .pend     (pend),
    .ovf      (ovf),
    .irq      (irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_en <= 1'b0;
      fall_en <= 1'b0;
    end else if (cfg_wr) begin
      rise_en <= bus_wdata[CFG_RISE_BIT];
      fall_en <= bus_wdata[CFG_FALL_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      bus_rdata <= '0;
      if (bus_addr == STAT_A) begin
        bus_rdata[PEND_POS] <= pend;
        bus_rdata[OVF_POS]  <= ovf;
      end else if (bus_addr == CFG_A) begin
        bus_rdata[CFG_RISE_BIT] <= rise_en;
        bus_rdata[CFG_FALL_BIT] <= fall_en;
      end
    end
  end
endmodule

// File: rtl/nmi_edge_monitor_chk.sv
module nmi_edge_monitor_chk #(
  parameter int unsigned ADDR_W = 14,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              evt,
  input logic              pend,
  input logic              ovf,
  input logic              rise_en,
  input logic              fall_en,
  input logic              irq,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata
);
  logic stat_sel;
  assign stat_sel = (addr == '0);

  AST_PEND_SET: assert property (@(posedge clk) disable iff (rst) evt |=> pend); // R3
  AST_W1C_PEND: assert property (@(posedge clk) disable iff (rst)
    (we && stat_sel && wdata[DATA_W-1] && !evt) |=> !pend); // R5
  AST_W0_HOLD: assert property (@(posedge clk) disable iff (rst)
    (pend && !(we && stat_sel && wdata[DATA_W-1])) |=> pend); // R5
  AST_OVF_COPY: assert property (@(posedge clk) disable iff (rst)
    evt |=> (ovf == $past(pend))); // R6
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (evt && we && stat_sel && wdata[DATA_W-1]) |=> pend); // R8
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (rst)
    ((pend || ovf) && (rise_en || fall_en)) |=> irq); // R7
  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (rst)
    (!pend && !ovf) |=> !irq); // R7
  AST_NO_ENABLE: assert property (@(posedge clk) disable iff (rst)
    (!rise_en && !fall_en) |-> !evt); // R9
  AST_STAT_RSVD: assert property (@(posedge clk) disable iff (rst)
    stat_sel |=> (rdata[DATA_W-3:0] == '0)); // R2
endmodule

bind nmi_edge_monitor nmi_edge_monitor_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .evt     (edge_evt),
  .pend    (pend),
  .ovf     (ovf),
  .rise_en (rise_en),
  .fall_en (fall_en),
  .irq     (irq_o),
  .we      (bus_we),
  .addr    (bus_addr),
  .wdata   (bus_wdata),
  .rdata   (bus_rdata)
);

// File: tb/sim_nmi_edge_monitor.sv
module sim_nmi_edge_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 14;
  localparam int DATA_W = 32;
  localparam logic [DATA_W-1:0] PEND = 32'h8000_0000;
  localparam logic [DATA_W-1:0] OVF  = 32'h4000_0000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              pad_i = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic              bus_we = 1'b0;
  logic [DATA_W-1:0] bus_rdata;
  logic              irq_o;

  typedef struct {
    logic [DATA_W-1:0] exp;
    string             tag;
  } item_t;

  item_t sb_q[$];
  logic  rd_req = 1'b0;
  logic  rd_req_d = 1'b0;
  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nmi_edge_monitor #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rst(rst), .pad_i(pad_i), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  always @(posedge clk) rd_req_d <= rd_req;

  // monitor: compare read responses against the scoreboard
  always @(negedge clk) begin
    if (rd_req_d) begin
      item_t it;
      n_chk++;
      if (sb_q.size() == 0) begin
        n_fail++;
        $display("FAIL scoreboard empty: actual %h expected none", bus_rdata);
      end else begin
        it = sb_q.pop_front();
        if (bus_rdata !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] e, input string tag);
    item_t it;
    it.exp = e;
    it.tag = tag;
    sb_q.push_back(it);
    bus_addr = a;
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    bus_addr = a;
    bus_wdata = d;
    bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    n_chk++;
    if (irq_o !== e) begin
      n_fail++;
      $display("FAIL %s: irq actual %b expected %b", tag, irq_o, e);
    end
  endtask

  // change the pad and wait until the flag update has happened
  task automatic pad_evt(input logic v);
    pad_i = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    rd(14'h0, '0, "R1 status after reset");
    rd(14'h8, '0, "R1 config after reset");
    chk_irq(1'b0, "R1 irq after reset");

    // R9: no enables, no events
    pad_evt(1'b1);
    pad_evt(1'b0);
    rd(14'h0, '0, "R9 no event with enables clear");

    // R2: register map
    wr(14'h8, 32'h1);
    rd(14'h8, 32'h1, "R2 config rise enable at bit0");
    rd(14'h4, '0, "R2 offset 0x4 reads zero");
    rd(14'h10, '0, "R2 reserved offset reads zero");

    // R3: latency of pad to pending flag
    pad_i = 1'b1;
    repeat (2) @(negedge clk);
    rd(14'h0, '0, "R3 not yet set two edges after pad");
    rd(14'h0, PEND, "R3 set on third edge R4 rising");
    chk_irq(1'b1, "R7 irq raised");

    // R4: falling ignored with rise-only
    pad_evt(1'b0);
    rd(14'h0, PEND, "R4 falling ignored rise-only");

    // R6: second event sets overrun
    pad_evt(1'b1);
    rd(14'h0, PEND | OVF, "R6 overrun on unserviced event");

    // R5: write 0 holds, write 1 clears
    wr(14'h0, 32'h0);
    rd(14'h0, PEND | OVF, "R5 write zero keeps flags");
    wr(14'h0, OVF);
    rd(14'h0, PEND, "R5 clear overrun only");

    // R6: overrun copies a zero pending
    pad_evt(1'b0);
    pad_evt(1'b1);
    rd(14'h0, PEND | OVF, "R6 overrun set again");
    wr(14'h0, PEND);
    rd(14'h0, OVF, "R5 clear pending only");
    wr(14'h8, 32'h2);
    rd(14'h8, 32'h2, "R2 config fall enable at bit1");
    pad_evt(1'b0);
    rd(14'h0, PEND, "R6 overrun copies cleared pending R4 falling");

    // R7: irq drops one cycle after flags clear
    wr(14'h0, PEND | OVF);
    chk_irq(1'b1, "R7 irq still high cycle of clear");
    @(negedge clk);
    chk_irq(1'b0, "R7 irq low after flags clear");

    // R4 both edges, R7 enables gate irq
    wr(14'h8, 32'h3);
    pad_evt(1'b1);
    rd(14'h0, PEND, "R4 rising with both enables");
    wr(14'h8, 32'h0);
    @(negedge clk);
    chk_irq(1'b0, "R7 irq low with enables off");
    rd(14'h0, PEND, "R7 flag kept with enables off");

    // R8: set wins over clearing write
    wr(14'h8, 32'h3);
    pad_i = 1'b0;
    repeat (2) @(negedge clk);
    wr(14'h0, PEND | OVF);
    @(negedge clk);
    rd(14'h0, PEND | OVF, "R8 event wins over clear");

    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    if (sb_q.size() != 0) begin
      n_chk++;
      n_fail++;
      $display("FAIL scoreboard: actual %0d left expected 0", sb_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule